// File: doc/BRIEF.md
# Butterfly Network Route Controller

This block is the routing control of a complete multistage butterfly network with N inputs built from two-by-two switching elements arranged in log2 N levels of N/2 elements each. Every cycle it accepts one header per input lane: a valid bit and a destination address. The lane number is the packet's source address. The block works out the path of every packet through all levels at once. Each element sets itself straight or crossed from one bit of the routing tag, which is the source address XOR the destination address. The block reports, one cycle later, the output position each packet reached and a flag for every element where two packets competed for the same output.

No packet data passes through the block. A packet that loses an output contest is dropped here, and the surrounding logic uses the delivered flags to decide on retries. There is exactly one path from each source to each destination, so a set of headers that causes no contest always delivers every packet to its own destination.

Top module: `bfly_route_ctrl`

## Requirements
- R1: While reset is high at a clock edge, the registered outputs become zero: out_ok, out_pos and out_conflict.
- R2: The routing tag of lane s is s XOR its destination. At level L (levels run L = 0 first, up to log2 N - 1), tag bit L = 0 sets the straight setting and keeps the position, and tag bit L = 1 sets the crossed setting and flips bit L of the current position.
- R3: Element k of level L joins the two positions that differ only in bit L: the low one is k with a 0 inserted at bit L, and the high one is that value plus 2^L. Its conflict flag is out_conflict bit L*N/2 + k.
- R4: When both inputs of an element hold valid packets that need the same output, its conflict flag is 1, the packet on the low position goes on, and the other packet is dropped. A dropped packet's lane reports out_ok = 0 and out_pos = 0.
- R5: A delivered packet reports out_ok = 1 and its lane field of out_pos (bits s*log2 N upward) equals its destination. Every full permutation that causes no conflict delivers all packets.
- R6: A lane with in_valid low reports out_ok = 0 and out_pos = 0, and its destination value causes no conflict anywhere.
- R7: The outputs are registered. They show the result of the headers sampled at the previous clock edge and do not change between edges.
- R8: The number of delivered lanes equals the number of valid inputs minus the number of conflict flags raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N | Header valid, one bit per source lane |
| in_dst | input | N*AW | Destination address per lane, lane s in bits s*AW upward |
| out_ok | output | N | Packet of this lane reached its output |
| out_pos | output | N*AW | Output position reached per lane, 0 if not delivered |
| out_conflict | output | AW*N/2 | One output-contest flag per element, level-major |

## Verification
The bench builds the block with an address width of 3, which gives an eight-lane, three-level network with twelve elements. At that size all 40320 full permutations can be applied, so every permutation with no conflict is confirmed to land each packet on its own destination. A bench-side path model, written from the level and element numbering rules, gives the expected flags for the contested cases. Further sweeps cover every single-packet source and destination pair, all lanes sent to one destination, idle lanes with arbitrary addresses, and pseudo-random valid masks.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Element setting chosen from one routing tag bit.
    typedef enum logic {
        SW_STRAIGHT = 1'b0,
        SW_CROSS    = 1'b1
    } sw_set_e;

    // Low position served by element k at level lvl: k with a 0 inserted at bit lvl.
    function automatic int pair_low(input int k, input int lvl);
        return ((k >> lvl) << (lvl + 1)) | (k & ((1 << lvl) - 1));
    endfunction

    // High position of the same element.
    function automatic int pair_high(input int k, input int lvl);
        return pair_low(k, lvl) + (1 << lvl);
    endfunction

    // Flat index of an element's conflict flag, level-major.
    function automatic int elem_index(input int lvl, input int k, input int half);
        return lvl * half + k;
    endfunction

endpackage

// File: rtl/bfly_elem.sv
module bfly_elem
    import bfly_pkg::*;
#(
    parameter int AW  = 3,
    parameter int LVL = 0
) (
    input  logic          a_v,
    input  logic [AW-1:0] a_src,
    input  logic [AW-1:0] a_tag,
    input  logic          b_v,
    input  logic [AW-1:0] b_src,
    input  logic [AW-1:0] b_tag,
    output logic          lo_v,
    output logic [AW-1:0] lo_src,
    output logic [AW-1:0] lo_tag,
    output logic          hi_v,
    output logic [AW-1:0] hi_src,
    output logic [AW-1:0] hi_tag,
    output logic          conflict
);

    sw_set_e a_set, b_set;
    logic a_wants_lo, a_wants_hi, b_wants_lo, b_wants_hi;

    always_comb begin
        a_set = sw_set_e'(a_tag[LVL]);
        b_set = sw_set_e'(b_tag[LVL]);
        // low input: straight stays low, cross goes high
        a_wants_lo = a_v && (a_set == SW_STRAIGHT);
        a_wants_hi = a_v && (a_set == SW_CROSS);
        // high input: straight stays high, cross goes low
        b_wants_lo = b_v && (b_set == SW_CROSS);
        b_wants_hi = b_v && (b_set == SW_STRAIGHT);
    end

    assign conflict = (a_wants_lo && b_wants_lo) || (a_wants_hi && b_wants_hi);

    // Low output: the low input has priority.
    always_comb begin
        lo_v   = 1'b0;
        lo_src = '0;
        lo_tag = '0;
        if (a_wants_lo) begin
            lo_v   = 1'b1;
            lo_src = a_src;
            lo_tag = a_tag;
        end else if (b_wants_lo) begin
            lo_v   = 1'b1;
            lo_src = b_src;
            lo_tag = b_tag;
        end
    end

    // High output: the low input has priority.
    always_comb begin
        hi_v   = 1'b0;
        hi_src = '0;
        hi_tag = '0;
        if (a_wants_hi) begin
            hi_v   = 1'b1;
            hi_src = a_src;
            hi_tag = a_tag;
        end else if (b_wants_hi) begin
            hi_v   = 1'b1;
            hi_src = b_src;
            hi_tag = b_tag;
        end
    end

endmodule

// File: rtl/bfly_level.sv
module bfly_level
    import bfly_pkg::*;
#(
    parameter int AW  = 3,
    parameter int LVL = 0,
    localparam int N    = 1 << AW,
    localparam int HALF = N / 2
) (
    input  logic [N-1:0]    in_v,
    input  logic [N*AW-1:0] in_src,
    input  logic [N*AW-1:0] in_tag,
    output logic [N-1:0]    out_v,
    output logic [N*AW-1:0] out_src,
    output logic [N*AW-1:0] out_tag,
    output logic [HALF-1:0] conflict
);

    for (genvar k = 0; k < HALF; k++) begin : g_elem
        localparam int LO = pair_low(k, LVL);
        localparam int HI = pair_high(k, LVL);

        bfly_elem #(
            .AW  (AW),
            .LVL (LVL)
        ) u_elem (
            .a_v      (in_v[LO]),
            .a_src    (in_src[LO*AW +: AW]),
            .a_tag    (in_tag[LO*AW +: AW]),
            .b_v      (in_v[HI]),
            .b_src    (in_src[HI*AW +: AW]),
            .b_tag    (in_tag[HI*AW +: AW]),
            .lo_v     (out_v[LO]),
            .lo_src   (out_src[LO*AW +: AW]),
            .lo_tag   (out_tag[LO*AW +: AW]),
            .hi_v     (out_v[HI]),
            .hi_src   (out_src[HI*AW +: AW]),
            .hi_tag   (out_tag[HI*AW +: AW]),
            .conflict (conflict[k])
        );
    end

endmodule

// File: rtl/bfly_gather.sv
module bfly_gather #(
    parameter int AW = 3,
    localparam int N  = 1 << AW,
    localparam int CW = AW * (N / 2)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    fin_v,
    input  logic [N*AW-1:0] fin_src,
    input  logic [CW-1:0]   cf_in,
    output logic [N-1:0]    out_ok,
    output logic [N*AW-1:0] out_pos,
    output logic [CW-1:0]   out_conflict
);

    logic [N-1:0]    ok_d;
    logic [N*AW-1:0] pos_d;

    // Map the final slot array back onto source lanes.
    always_comb begin
        ok_d  = '0;
        pos_d = '0;
        for (int s = 0; s < N; s++) begin
            for (int j = 0; j < N; j++) begin
                if (fin_v[j] && (fin_src[j*AW +: AW] == AW'(s))) begin
                    ok_d[s]            = 1'b1;
                    pos_d[s*AW +: AW]  = AW'(j);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_ok       <= '0;
            out_pos      <= '0;
            out_conflict <= '0;
        end else begin
            out_ok       <= ok_d;
            out_pos      <= pos_d;
            out_conflict <= cf_in;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_ok == '0 && out_pos == '0 && out_conflict == '0));

endmodule

// File: rtl/bfly_route_ctrl.sv
module bfly_route_ctrl
    import bfly_pkg::*;
#(
    parameter int AW = 3,
    localparam int N    = 1 << AW,
    localparam int HALF = N / 2,
    localparam int CW   = AW * HALF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    in_valid,
    input  logic [N*AW-1:0] in_dst,
    output logic [N-1:0]    out_ok,
    output logic [N*AW-1:0] out_pos,
    output logic [CW-1:0]   out_conflict
);

    logic [N-1:0]    st_v   [AW+1];
    logic [N*AW-1:0] st_src [AW+1];
    logic [N*AW-1:0] st_tag [AW+1];
    logic [CW-1:0]   cf_all;

    // Level 0 inputs: source is the lane number, tag is source XOR destination.
    for (genvar s = 0; s < N; s++) begin : g_seed
        assign st_src[0][s*AW +: AW] = AW'(s);
        assign st_tag[0][s*AW +: AW] = AW'(s) ^ in_dst[s*AW +: AW];
    end
    assign st_v[0] = in_valid;

    for (genvar l = 0; l < AW; l++) begin : g_lvl
        bfly_level #(
            .AW  (AW),
            .LVL (l)
        ) u_level (
            .in_v     (st_v[l]),
            .in_src   (st_src[l]),
            .in_tag   (st_tag[l]),
            .out_v    (st_v[l+1]),
            .out_src  (st_src[l+1]),
            .out_tag  (st_tag[l+1]),
            .conflict (cf_all[elem_index(l, 0, HALF) +: HALF])
        );
    end

    bfly_gather #(
        .AW (AW)
    ) u_gather (
        .clk          (clk),
        .rst          (rst),
        .fin_v        (st_v[AW]),
        .fin_src      (st_src[AW]),
        .cf_in        (cf_all),
        .out_ok       (out_ok),
        .out_pos      (out_pos),
        .out_conflict (out_conflict)
    );

    for (genvar s = 0; s < N; s++) begin : g_lane_chk
        // R5
        delivered_at_dst_chk: assert property (@(posedge clk) disable iff (rst)
            out_ok[s] |-> out_pos[s*AW +: AW] == $past(in_dst[s*AW +: AW]));
        // R6
        idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(in_valid[s]) |-> (!out_ok[s] && out_pos[s*AW +: AW] == '0));
    end

    // R8
    delivery_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b0) |->
        ($countones(out_ok) == $countones($past(in_valid)) - $countones(out_conflict)));

    // R4
    conflict_needs_two_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) == 1'b0 && $countones($past(in_valid)) < 2) |-> out_conflict == '0);

endmodule

// File: tb/tb_bfly_route_ctrl.sv
module tb_bfly_route_ctrl;
    localparam int  AW   = 3;
    localparam int  N    = 1 << AW;
    localparam int  HALF = N / 2;
    localparam int  CW   = AW * HALF;
    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_valid = '0;
    logic [N*AW-1:0] in_dst = '0;
    logic [N-1:0]    out_ok;
    logic [N*AW-1:0] out_pos;
    logic [CW-1:0]   out_conflict;

    bfly_route_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
        .out_ok(out_ok), .out_pos(out_pos), .out_conflict(out_conflict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int vv [N];
    int dv [N];
    int perm [N];
    logic [N-1:0]    e_ok;
    logic [N*AW-1:0] e_pos;
    logic [CW-1:0]   e_cf;
    logic [31:0]     lfsr = 32'h1ACE_B00C;

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Path model built from the level numbering and priority rules.
    task automatic model();
        int sv [N]; int ss [N]; int nv [N]; int ns [N];
        e_cf = '0;
        for (int i = 0; i < N; i++) begin sv[i] = vv[i]; ss[i] = i; end
        for (int l = 0; l < AW; l++) begin
            for (int j = 0; j < N; j++) begin nv[j] = 0; ns[j] = 0; end
            for (int k = 0; k < HALF; k++) begin
                int lo; int hi; int ac; int bc; int wa; int wb;
                lo = ((k >> l) << (l + 1)) | (k & ((1 << l) - 1));
                hi = lo + (1 << l);
                ac = ((ss[lo] ^ dv[ss[lo]]) >> l) & 1;
                bc = ((ss[hi] ^ dv[ss[hi]]) >> l) & 1;
                wa = ac ? hi : lo;
                wb = bc ? lo : hi;
                if (sv[lo] != 0) begin nv[wa] = 1; ns[wa] = ss[lo]; end
                if (sv[hi] != 0) begin
                    if (sv[lo] != 0 && wa == wb) e_cf[l*HALF + k] = 1'b1;
                    else begin nv[wb] = 1; ns[wb] = ss[hi]; end
                end
            end
            for (int j = 0; j < N; j++) begin sv[j] = nv[j]; ss[j] = ns[j]; end
        end
        e_ok = '0;
        e_pos = '0;
        for (int j = 0; j < N; j++) begin
            if (sv[j] != 0) begin
                e_ok[ss[j]] = 1'b1;
                e_pos[ss[j]*AW +: AW] = AW'(j);
            end
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            in_valid[i] = (vv[i] != 0);
            in_dst[i*AW +: AW] = AW'(dv[i]);
        end
    endtask

    // Called at a falling edge; ends at the next falling edge.
    task automatic apply_check();
        logic [N*AW-1:0] dst_flat;
        bit all_valid;
        drive();
        model();
        dst_flat = in_dst;
        all_valid = (in_valid == '1);
        @(posedge clk);
        @(negedge clk);
        chk(out_ok == e_ok, "R4", "delivered lanes", longint'(out_ok), longint'(e_ok));
        chk(out_pos == e_pos, "R5", "positions reached", longint'(out_pos), longint'(e_pos));
        chk(out_conflict == e_cf, "R3", "conflict flags", longint'(out_conflict), longint'(e_cf));
        chk($countones(out_ok) == $countones(in_valid) - $countones(out_conflict), "R8",
            "delivered count", longint'($countones(out_ok)),
            longint'($countones(in_valid) - $countones(out_conflict)));
        if (all_valid && e_cf == '0)
            chk(out_ok == '1 && out_pos == dst_flat, "R5", "conflict-free permutation",
                longint'(out_pos), longint'(dst_flat));
    endtask

    task automatic next_perm(output bit more);
        int i; int j; int t;
        more = 0;
        i = N - 2;
        while (i >= 0 && perm[i] >= perm[i+1]) i--;
        if (i < 0) return;
        j = N - 1;
        while (perm[j] <= perm[i]) j--;
        t = perm[i]; perm[i] = perm[j]; perm[j] = t;
        for (int a = i + 1, b = N - 1; a < b; a++, b--) begin
            t = perm[a]; perm[a] = perm[b]; perm[b] = t;
        end
        more = 1;
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit more;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(out_ok == '0 && out_pos == '0 && out_conflict == '0, "R1", "reset outputs",
            longint'({out_ok, out_conflict}), 0);
        rst = 1'b0;

        // R7: one cycle of latency, no change before the edge
        for (int i = 0; i < N; i++) begin vv[i] = 1; dv[i] = N - 1 - i; end
        drive();
        #1;
        chk(out_ok == '0, "R7", "before edge", longint'(out_ok), 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_ok == '1, "R7", "after edge", longint'(out_ok), longint'({N{1'b1}}));

        // R2: every single-packet source/destination pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                for (int i = 0; i < N; i++) begin vv[i] = 0; dv[i] = (i * 5 + 3) % N; end
                vv[s] = 1;
                dv[s] = d;
                apply_check();
                chk(out_ok == (N'(1) << s) && out_pos[s*AW +: AW] == AW'(d) && out_conflict == '0,
                    "R2", "single packet path", longint'(out_pos), longint'(d));
            end
        end

        // R6: idle lanes with arbitrary addresses
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < N; i++) begin step_lfsr(); vv[i] = 0; dv[i] = int'(lfsr[2:0]); end
            apply_check();
            chk(out_ok == '0 && out_pos == '0 && out_conflict == '0, "R6", "idle lanes",
                longint'({out_ok, out_conflict}), 0);
        end

        // R4: every lane aims at one destination
        for (int d = 0; d < N; d++) begin
            for (int i = 0; i < N; i++) begin vv[i] = 1; dv[i] = d; end
            apply_check();
            chk($countones(out_ok) == 1 && $countones(out_conflict) == N - 1, "R4",
                "hot destination", longint'($countones(out_conflict)), longint'(N - 1));
            chk(out_ok[0] == 1'b1 && out_pos[AW-1:0] == AW'(d), "R4", "lane 0 wins",
                longint'(out_ok), 1);
        end

        // R5: all full permutations
        for (int i = 0; i < N; i++) perm[i] = i;
        more = 1;
        while (more) begin
            for (int i = 0; i < N; i++) begin vv[i] = 1; dv[i] = perm[i]; end
            apply_check();
            next_perm(more);
        end

        // R3/R4/R8: pseudo-random masks and destinations
        for (int r = 0; r < 3000; r++) begin
            for (int i = 0; i < N; i++) begin
                step_lfsr();
                vv[i] = int'(lfsr[5] | lfsr[9]);
                dv[i] = int'(lfsr[2:0]);
            end
            apply_check();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule